// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is a 64-bit command register, reached through a 32-bit memory-mapped write and read port, that turns a software command into one outgoing inter-processor interrupt message. The register is split into two words: the word at the upper offset (0x10 above the lower one) carries the destination processor number in its top byte. The word at the lower offset carries the vector, the delivery mode, the trigger mode, the level bit and the destination shorthand. Software fills the upper word first. Writing the lower word is the only thing that launches a message.

At launch the block resolves the shorthand into a bit mask of target processors. It decides the level of the message and, for a start-up message, forms the start address from the vector page number. It latches all of this into a message bundle offered on a valid/ready output. A busy flag, readable in the lower word, stays set from the launching write until the downstream side accepts the message. Software polls it until it reads clear. A lower-word write that arrives while busy is dropped and sets a sticky error flag.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset both words read as zero, the error flag is clear and `msgValid` is low.
- R2: A write at the upper offset (0x10) stores all 32 bits, which read back unchanged, and launches no message. The destination number is bits 31:24 of this word.
- R3: A write at the lower offset (0x00) while not busy raises `msgValid` in the next cycle, and the busy flag (lower word bit 12) reads 1 from that cycle on.
- R4: `msgValid` and the busy flag stay set until a cycle with `msgValid` and `msgReady` both high; both are clear in the cycle after that one.
- R5: A lower-word write while busy changes neither the stored lower word nor the pending message, and sets the error flag (lower word bit 13), which then stays set until reset.
- R6: Lower word bits 19:18 pick the targets among NUM_CPU processors, with this processor at index SELF_ID. 00 selects the single processor named by the destination number, or none when that number is NUM_CPU or more. 01 selects SELF_ID only. 10 selects all processors. 11 selects all processors except SELF_ID.
- R7: Lower word bit 15 is the trigger mode (1 level, 0 edge). With level trigger the message level follows bit 14 (1 assert, 0 deassert). An edge-triggered message always carries level 1.
- R8: Lower word bits 10:8 are the delivery mode (101 INIT, 110 start-up), and bits 7:0 are the vector. For a start-up message `msgStartAddr` equals the vector shifted left by PAGE_SHIFT; for every other mode it is zero.
- R9: Lower word bits 17:16 are the remote read status and always read 00 (invalid); values written there are discarded.
- R10: While a message waits, its fields stay stable, including across upper-word writes; such a write affects only the next launch.
- R11: Writes to any address other than the two word offsets change nothing and launch nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W (8) | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W (8) | Read byte offset |
| rdData | output | 32 | Read data, combinational from rdAddr |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Downstream accepts the message |
| msgTargets | output | NUM_CPU (8) | Resolved target processor mask |
| msgVector | output | 8 | Vector field |
| msgMode | output | 3 | Delivery mode |
| msgLevelTrig | output | 1 | 1 for level-triggered message |
| msgLevel | output | 1 | 1 assert, 0 deassert |
| msgStartAddr | output | START_W (20) | Start-up address, zero for other modes |

## Verification
The assertions watch, on every cycle, the busy handshake: a launch sets busy, valid holds while ready is low and drops after acceptance. They also check that the error flag never clears, that the pending fields stay stable while waiting, that the remote read status always reads zero and that the start address stays zero outside start-up mode. Only the bench's scenarios can show that each shorthand yields the right mask for a given destination and self index. The same holds for the level rule under edge and level triggers, for a dropped write leaving both the register and the in-flight message untouched, and for stray addresses having no effect.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  // lower-word field positions
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int BUSY_BIT  = 12;
  localparam int ERR_BIT   = 13;
  localparam int LVL_BIT   = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  // upper-word destination field
  localparam int DEST_LSB  = 24;

  localparam logic [2:0] MODE_INIT    = 3'b101;
  localparam logic [2:0] MODE_STARTUP = 3'b110;

  typedef enum logic [1:0] {
    SH_NONE    = 2'b00,
    SH_SELF    = 2'b01,
    SH_ALL_INC = 2'b10,
    SH_ALL_EXC = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic loadLo;   // accepted lower-word write, also the launch
    logic loadHi;   // upper-word write
  } strobe_t;
endpackage

// File: rtl/ipi_cmd_ctrl.sv
module ipi_cmd_ctrl
  import ipi_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] HI_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              msgReady,
  output strobe_t           strobes,
  output logic              busy,
  output logic              sendErr
);
  logic hitLo, hitHi, accepted;

  assign hitLo    = wrEn && (wrAddr == LO_OFF);
  assign hitHi    = wrEn && (wrAddr == HI_OFF);
  assign accepted = busy && msgReady;

  always_comb begin
    strobes.loadLo = hitLo && !busy;
    strobes.loadHi = hitHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sendErr <= 1'b0;
    end else begin
      if (strobes.loadLo)  busy <= 1'b1;
      else if (accepted)   busy <= 1'b0;
      if (hitLo && busy)   sendErr <= 1'b1;
    end
  end

  a_r3_launch_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (hitLo && !busy) |=> busy);
  a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !msgReady) |=> busy);
  a_r4_clear_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (busy && msgReady && !hitLo) |=> !busy);
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sendErr |=> sendErr);
  a_r5_err_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    (hitLo && busy) |=> sendErr);
endmodule

// File: rtl/ipi_cmd_dpath.sv
module ipi_cmd_dpath
  import ipi_cmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] HI_OFF = 8'h10,
  parameter int NUM_CPU    = 8,
  parameter int SELF_ID    = 2,
  parameter int PAGE_SHIFT = 12,
  localparam int START_W   = 8 + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic               busy,
  input  logic               sendErr,
  input  logic [31:0]        wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [31:0]        rdData,
  input  logic               msgReady,
  output logic [NUM_CPU-1:0] msgTargets,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic               msgLevelTrig,
  output logic               msgLevel,
  output logic [START_W-1:0] msgStartAddr
);
  // stored lower-word fields (status bits are not stored)
  logic [13:0] loUpper;   // bits 31:18
  logic [1:0]  loTrigLvl; // bits 15:14
  logic [11:0] loLower;   // bits 11:0
  logic [31:0] hiWord;

  // launch-time decode of the incoming lower word
  shorthand_e         newSh;
  logic [7:0]         destId;
  logic [NUM_CPU-1:0] newTargets;
  logic [2:0]         newMode;
  logic [7:0]         newVec;
  logic               newTrig;
  logic               newLevel;
  logic [START_W-1:0] newStart;

  assign newSh    = shorthand_e'(wrData[SH_LSB +: 2]);
  assign destId   = hiWord[DEST_LSB +: 8];
  assign newMode  = wrData[MODE_LSB +: 3];
  assign newVec   = wrData[VEC_LSB +: 8];
  assign newTrig  = wrData[TRIG_BIT];
  assign newLevel = newTrig ? wrData[LVL_BIT] : 1'b1;
  assign newStart = (newMode == MODE_STARTUP) ? {newVec, {PAGE_SHIFT{1'b0}}} : '0;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_target
    always_comb begin
      unique case (newSh)
        SH_NONE:    newTargets[g] = (destId == 8'(g));
        SH_SELF:    newTargets[g] = (g == SELF_ID);
        SH_ALL_INC: newTargets[g] = 1'b1;
        SH_ALL_EXC: newTargets[g] = (g != SELF_ID);
        default:    newTargets[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loUpper      <= '0;
      loTrigLvl    <= '0;
      loLower      <= '0;
      hiWord       <= '0;
      msgTargets   <= '0;
      msgVector    <= '0;
      msgMode      <= '0;
      msgLevelTrig <= 1'b0;
      msgLevel     <= 1'b0;
      msgStartAddr <= '0;
    end else begin
      if (strobes.loadHi) hiWord <= wrData;
      if (strobes.loadLo) begin
        loUpper      <= wrData[31:18];
        loTrigLvl    <= wrData[15:14];
        loLower      <= wrData[11:0];
        msgTargets   <= newTargets;
        msgVector    <= newVec;
        msgMode      <= newMode;
        msgLevelTrig <= newTrig;
        msgLevel     <= newLevel;
        msgStartAddr <= newStart;
      end
    end
  end

  always_comb begin
    if (rdAddr == LO_OFF)
      rdData = {loUpper, 2'b00, loTrigLvl, sendErr, busy, loLower};
    else if (rdAddr == HI_OFF)
      rdData = hiWord;
    else
      rdData = '0;
  end

  a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !msgReady) |=> $stable({msgTargets, msgVector, msgMode,
                                     msgLevelTrig, msgLevel, msgStartAddr}));
  a_r9_remote_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == LO_OFF) |-> (rdData[17:16] == 2'b00));
  a_r8_start_only_startup: assert property (@(posedge clk) disable iff (!rstN)
    (busy && msgMode != MODE_STARTUP) |-> (msgStartAddr == '0));
  a_r7_edge_asserts: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !msgLevelTrig) |-> msgLevel);
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_cmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] LO_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] HI_OFF = 8'h10,
  parameter int NUM_CPU    = 8,
  parameter int SELF_ID    = 2,
  parameter int PAGE_SHIFT = 12,
  localparam int START_W   = 8 + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [31:0]        rdData,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [NUM_CPU-1:0] msgTargets,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic               msgLevelTrig,
  output logic               msgLevel,
  output logic [START_W-1:0] msgStartAddr
);
  strobe_t strobes;
  logic    busy, sendErr;

  ipi_cmd_ctrl #(.ADDR_W(ADDR_W), .LO_OFF(LO_OFF), .HI_OFF(HI_OFF)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .msgReady(msgReady), .strobes(strobes), .busy(busy), .sendErr(sendErr)
  );

  ipi_cmd_dpath #(
    .ADDR_W(ADDR_W), .LO_OFF(LO_OFF), .HI_OFF(HI_OFF),
    .NUM_CPU(NUM_CPU), .SELF_ID(SELF_ID), .PAGE_SHIFT(PAGE_SHIFT)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy), .sendErr(sendErr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .msgReady(msgReady),
    .msgTargets(msgTargets), .msgVector(msgVector), .msgMode(msgMode),
    .msgLevelTrig(msgLevelTrig), .msgLevel(msgLevel), .msgStartAddr(msgStartAddr)
  );

  assign msgValid = busy;
endmodule

// File: tb/test_ipi_cmd_reg.sv
module test_ipi_cmd_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LO = 8'h00;
  localparam logic [7:0] HI = 8'h10;

  typedef struct packed {
    logic [7:0]  targets;
    logic [7:0]  vector;
    logic [2:0]  mode;
    logic        trig;
    logic        level;
    logic [19:0] start;
  } msg_t;

  logic clk = 0, rstN = 0, wrEn = 0, msgReady = 1;
  logic [7:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, rdData;
  logic msgValid, msgLevelTrig, msgLevel;
  logic [7:0] msgTargets, msgVector;
  logic [2:0] msgMode;
  logic [19:0] msgStartAddr;

  int tests = 0, fails = 0;
  msg_t expQ[$];
  logic expErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_reg i_ipi_cmd_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .msgValid(msgValid), .msgReady(msgReady),
    .msgTargets(msgTargets), .msgVector(msgVector), .msgMode(msgMode),
    .msgLevelTrig(msgLevelTrig), .msgLevel(msgLevel), .msgStartAddr(msgStartAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] loView(input logic [31:0] d, input logic b, input logic e);
    logic [31:0] v;
    v = d & ~32'h0003_3000;
    v[13] = e;
    v[12] = b;
    return v;
  endfunction

  function automatic msg_t predict(input logic [31:0] lo, input logic [31:0] hi);
    msg_t m;
    logic [7:0] d;
    d = hi[31:24];
    case (lo[19:18])
      2'b00: m.targets = (d < 8) ? (8'h01 << d) : 8'h00;
      2'b01: m.targets = 8'h04;
      2'b10: m.targets = 8'hFF;
      default: m.targets = 8'hFB;
    endcase
    m.vector = lo[7:0];
    m.mode   = lo[10:8];
    m.trig   = lo[15];
    m.level  = lo[15] ? lo[14] : 1'b1;
    m.start  = (lo[10:8] == 3'b110) ? {lo[7:0], 12'h000} : 20'h0;
    return m;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  // monitor: compares each accepted message against the scoreboard
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      msg_t got, exp;
      got = '{msgTargets, msgVector, msgMode, msgLevelTrig, msgLevel, msgStartAddr};
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R3/R11 unexpected message actual=%h expected=none", got);
      end else begin
        exp = expQ.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL R6/R7/R8/R10 message actual=%h expected=%h", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic launch(input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] r;
    expQ.push_back(predict(lo, hi));
    wr(LO, lo);
    rd(LO, r);
    check("R3 busy after launch", {31'd0, r[12]}, 32'd1);
    check("R9 remote status reads 00", {30'd0, r[17:16]}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r, hi, lo1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rd(LO, r); check("R1 lower word at reset", r, 32'd0);
    rd(HI, r); check("R1 upper word at reset", r, 32'd0);
    check("R1 valid at reset", {31'd0, msgValid}, 32'd0);

    hi = 32'h0300_0000;
    wr(HI, hi);
    rd(HI, r); check("R2 upper readback", r, hi);
    check("R2 no launch", {31'd0, msgValid}, 32'd0);

    // R4/R5/R10: hold ready low, INIT level assert to processor 3
    msgReady = 0;
    lo1 = 32'h0000_C500;
    expQ.push_back(predict(lo1, hi));
    wr(LO, lo1);
    check("R3 valid after launch", {31'd0, msgValid}, 32'd1);
    rd(LO, r); check("R3 lower readback busy", r, loView(lo1, 1, 0));
    wr(HI, 32'h0500_0000);
    hi = 32'h0500_0000;
    wr(LO, 32'h000C_0677);
    expErr = 1;
    rd(LO, r); check("R5 dropped write leaves word, sets error", r, loView(lo1, 1, 1));
    repeat (4) @(negedge clk);
    check("R4 valid holds without ready", {31'd0, msgValid}, 32'd1);
    msgReady = 1;
    @(negedge clk);
    @(negedge clk);
    check("R4 valid clear after accept", {31'd0, msgValid}, 32'd0);
    rd(LO, r); check("R4 busy clear, R5 error sticky", r, loView(lo1, 0, 1));

    // R6 shorthands, R7 edge level
    launch(32'h0004_0040, hi);           // self, edge, bit14=0
    launch(32'h0008_0041, hi);           // all including self
    launch(32'h000C_0042, hi);           // all excluding self
    launch(32'h0003_0643, hi);           // none, dest 5, start-up, status bits written 11
    // R8 start-up address with vector 0x9A
    launch(32'h0000_069A, hi);
    // R7 level deassert
    launch(32'h0000_8500, hi);
    // R6 out-of-range destination
    hi = 32'h0900_0000;
    wr(HI, hi);
    launch(32'h0000_0011, hi);
    rd(LO, r); check("R5 error still set", {31'd0, r[13]}, 32'd1);

    // R11 stray address
    wr(8'h08, 32'hDEAD_BEEF);
    check("R11 stray write no launch", {31'd0, msgValid}, 32'd0);
    rd(8'h08, r); check("R11 stray read zero", r, 32'd0);
    rd(HI, r); check("R11 upper unchanged", r, hi);
    rd(LO, r); check("R11 lower unchanged", r, loView(32'h0000_0011, 0, 1));

    // R1 error clears only on reset
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    rd(LO, r); check("R1 lower word after reset", r, 32'd0);

    repeat (3) @(negedge clk);
    check("R3 all expected messages seen", expQ.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule